// File: doc/BRIEF.md
# Constant-Divisor Triplet Degrouper

This block unpacks one grouped audio codeword into the three quantized samples it carries. A codeword encodes three consecutive samples of a 3-, 5- or 9-level quantizer as a single base-L number. The block recovers them least-significant digit first: each cycle it emits the current value modulo L and keeps the integer quotient for the next cycle. Three samples leave on three consecutive clocks.

The division by L uses no divider, multiplier or lookup table. Each divisor sits one away from a power of two (3 = 4-1, 5 = 4+1, 9 = 8+1). A quotient estimate is therefore a short series of right-shifted copies of the value, summed with alternating signs for the plus-one divisors and all positive for the minus-one divisor. For the minus-one divisor a constant one enters as a carry-in. The remainder implied by that estimate is formed with a shift and an add. One compare-and-adjust step then moves the quotient by at most one and the remainder by at most one divisor. The corrected quotient is written back into the working register, so the throughput is one sample per clock.

A new codeword is taken while the block is idle, or on the edge that issues the third sample of the current one, which allows gap-free streaming.

Top module: `triplet_degrouper`

## Requirements
- R1: `mode_i` selects the level count: 0 selects 3 levels with a 5-bit codeword, 1 selects 5 levels with a 7-bit codeword, and 2 selects 9 levels with a 10-bit codeword. A start with `mode_i` = 3 is ignored, and the block stays idle.
- R2: Suppose a start is accepted at clock edge E0. At edges E0+1, E0+2 and E0+3, `sample_o` shows v mod L, (v div L) mod L and (v div L div L) mod L, where v is the codeword after R5 masking and L is the level count.
- R3: `sample_o` is 4 bits wide, zero-extended, and always below the level count of its codeword (largest value 2, 4 or 8).
- R4: `sample_valid_o` is high for exactly the three cycles after E0+1, E0+2 and E0+3. `sample_last_o` is high only together with the third sample. Neither is high in the cycle right after acceptance.
- R5: Codeword bits above the mode's codeword width (bits 9:5 in mode 0, bits 9:7 in mode 1) are ignored.
- R6: A start is accepted when `busy_o` is low, or on the edge that issues the third sample. In the second case the new codeword's first sample follows on the next edge, `busy_o` stays high throughout, and there is no gap in `sample_valid_o`.
- R7: `busy_o` is high from the edge after acceptance until the third sample is issued. A start seen at any other edge while busy is ignored and does not change the samples in progress.
- R8: An accepted codeword at or above L cubed (27, 125 or 729 after masking) sets `range_err_o`. The flag stays set until reset. The three samples for that codeword still follow the R2 rule.
- R9: A synchronous active-low `rst_n` clears the working value, `sample_valid_o`, `sample_last_o`, `busy_o` and `range_err_o` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to load `codeword_i` under `mode_i` |
| mode_i | input | 2 | Level select: 0 = 3 levels, 1 = 5, 2 = 9, 3 = reserved |
| codeword_i | input | 10 | Grouped codeword, right-aligned |
| sample_o | output | 4 | Recovered sample, zero-extended |
| sample_valid_o | output | 1 | `sample_o` holds a new sample this cycle |
| sample_last_o | output | 1 | Third sample of the codeword |
| busy_o | output | 1 | Degrouping in progress |
| range_err_o | output | 1 | Sticky flag for an out-of-range codeword |

## Verification
With acceptance at edge E0, `busy_o` and `range_err_o` change at E0. The three samples with their valid and last flags appear at E0+1, E0+2 and E0+3. Every scenario task drives its inputs on the falling edge and reads the outputs on the following falling edges, one per rising edge. Each comparison is therefore tied to a known register stage rather than to a search window. The back-to-back and ignored-start scenarios place their second start at chosen falling edges, so the edge that either accepts or drops it is known in advance. Every legal codeword of every mode is compared against quotients and remainders computed by the bench.

// File: rtl/degroup_pkg.sv
// Shared definitions for the triplet degrouper.
// Assumes at most a 10-bit codeword and 4-bit samples (level counts up to 9).
package degroup_pkg;

    localparam int CW_MAX_W  = 10;   // widest grouped codeword
    localparam int SMP_W     = 4;    // zero-extended sample width
    localparam int N_PER_CW  = 3;    // samples carried by one codeword

    // Level-count select as seen on the mode port
    typedef enum logic [1:0] {
        LVL3     = 2'd0,
        LVL5     = 2'd1,
        LVL9     = 2'd2,
        LVL_RSVD = 2'd3
    } lvl_mode_e;

    // Divisor (number of quantization levels) for a mode
    function automatic logic [SMP_W-1:0] lvl_divisor(input lvl_mode_e m);
        case (m)
            LVL3:    return SMP_W'(3);
            LVL5:    return SMP_W'(5);
            default: return SMP_W'(9);
        endcase
    endfunction

    // Significant codeword bits for a mode
    function automatic int unsigned lvl_cw_bits(input lvl_mode_e m);
        case (m)
            LVL3:    return 5;
            LVL5:    return 7;
            LVL9:    return 10;
            default: return 0;
        endcase
    endfunction

    // First out-of-range codeword value (level count cubed)
    function automatic int unsigned lvl_cube(input lvl_mode_e m);
        case (m)
            LVL3:    return 27;
            LVL5:    return 125;
            default: return 729;
        endcase
    endfunction

endpackage

// File: rtl/dg_approx.sv
// Quotient estimator for division by 3, 5 or 9 using right shifts only.
// For 2^k+1 divisors: alternating sum of val>>k, val>>2k, ...
// For 3 = 2^2-1: plain sum of val>>2, val>>4, ... plus one as carry-in.
// Assumes the value is masked to its mode width (5/7/10 bits). Under that
// assumption the estimate lies within one of the true quotient.
module dg_approx
    import degroup_pkg::*;
#(
    parameter int W  = CW_MAX_W,
    parameter int AW = W + 5
) (
    input  logic [W-1:0]         val_i,
    input  lvl_mode_e            mode_i,
    output logic signed [AW-1:0] q_est_o
);

    localparam int N_K2 = W / 2;   // radix-4 digit terms
    localparam int N_K3 = W / 3;   // radix-8 digit terms

    logic [W-1:0] term4 [N_K2];
    logic [W-1:0] term8 [N_K3];

    // Shifted operands, one per digit position
    for (genvar g = 0; g < N_K2; g++) begin : g_rad4
        assign term4[g] = val_i >> (2 * (g + 1));
    end
    for (genvar g = 0; g < N_K3; g++) begin : g_rad8
        assign term8[g] = val_i >> (3 * (g + 1));
    end

    logic signed [AW-1:0] sum_pos4;   // divisor 3 series
    logic signed [AW-1:0] sum_alt4;   // divisor 5 series
    logic signed [AW-1:0] sum_alt8;   // divisor 9 series

    // Combine the shifted operands into the three candidate estimates
    always_comb begin
        sum_pos4 = AW'(1);   // carry-in stands for the last one-digit operand
        sum_alt4 = '0;
        sum_alt8 = '0;
        for (int i = 0; i < N_K2; i++) begin
            sum_pos4 = sum_pos4 + $signed(AW'(term4[i]));
            if (i % 2 == 0) sum_alt4 = sum_alt4 + $signed(AW'(term4[i]));
            else            sum_alt4 = sum_alt4 - $signed(AW'(term4[i]));
        end
        for (int i = 0; i < N_K3; i++) begin
            if (i % 2 == 0) sum_alt8 = sum_alt8 + $signed(AW'(term8[i]));
            else            sum_alt8 = sum_alt8 - $signed(AW'(term8[i]));
        end
    end

    // Pick the estimate for the active divisor
    always_comb begin
        case (mode_i)
            LVL3:    q_est_o = sum_pos4;
            LVL5:    q_est_o = sum_alt4;
            default: q_est_o = sum_alt8;
        endcase
    end

endmodule

// File: rtl/dg_correct.sv
// Turns a quotient estimate (within one of the true value) into the exact
// quotient and remainder. The back-multiplication is one shift plus one add.
// One signed compare then moves the result by a single step either way.
module dg_correct
    import degroup_pkg::*;
#(
    parameter int W  = CW_MAX_W,
    parameter int AW = W + 5
) (
    input  logic [W-1:0]         val_i,
    input  logic signed [AW-1:0] q_est_i,
    input  lvl_mode_e            mode_i,
    output logic [AW-1:0]        q_o,
    output logic [AW-1:0]        r_o
);

    logic signed [AW-1:0] back_prod;
    logic signed [AW-1:0] r_est;
    logic signed [AW-1:0] div_s;

    // Estimate times divisor, by shift and add or subtract
    always_comb begin
        case (mode_i)
            LVL3:    back_prod = (q_est_i <<< 2) - q_est_i;
            LVL5:    back_prod = (q_est_i <<< 2) + q_est_i;
            default: back_prod = (q_est_i <<< 3) + q_est_i;
        endcase
    end

    // Remainder implied by the estimate, and the divisor at the same width
    always_comb begin
        r_est = $signed(AW'(val_i)) - back_prod;
        div_s = $signed(AW'(lvl_divisor(mode_i)));
    end

    // Single-step correction into the exact quotient and remainder
    always_comb begin
        if (r_est < 0) begin
            r_o = AW'(r_est + div_s);
            q_o = AW'(q_est_i - 1);
        end else if (r_est >= div_s) begin
            r_o = AW'(r_est - div_s);
            q_o = AW'(q_est_i + 1);
        end else begin
            r_o = AW'(r_est);
            q_o = AW'(q_est_i);
        end
    end

endmodule

// File: rtl/dg_seq.sv
// Sequencer: counts the samples of one codeword and decides on acceptance.
// It accepts a start when idle, or on the edge that issues the last sample.
// Assumes the caller qualifies start with a legal mode.
module dg_seq #(
    parameter int NSMP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic busy_o,
    output logic last_o
);

    localparam int CNTW = (NSMP > 1) ? $clog2(NSMP) : 1;
    localparam logic [CNTW-1:0] LAST_IDX = CNTW'(NSMP - 1);

    logic [CNTW-1:0] idx_q;
    logic            busy_q;

    // Acceptance window and last-sample strobe
    always_comb begin
        last_o = busy_q && (idx_q == LAST_IDX);
        load_o = start_i && (!busy_q || last_o);
        busy_o = busy_q;
    end

    // Sample counter and busy state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (load_o) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (busy_q) begin
            if (idx_q == LAST_IDX) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + CNTW'(1);
            end
        end
    end

    // R7: busy persists until the last sample has been issued
    assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !last_o) |=> busy_q);

    // R6: a start on the last-sample edge keeps the block busy
    assert_chain_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && start_i) |=> (busy_q && idx_q == '0));

endmodule

// File: rtl/triplet_degrouper.sv
// Triplet degrouper top. It registers a masked codeword and then, on each of
// three clocks, emits value mod L and keeps value div L. The quotient is
// recirculated into the working register. Assumes L in {3,5,9}; mode 3 is
// rejected at the input.
module triplet_degrouper
    import degroup_pkg::*;
#(
    parameter int CW_W = CW_MAX_W,
    parameter int SW   = SMP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      mode_i,
    input  logic [CW_W-1:0] codeword_i,
    output logic [SW-1:0]   sample_o,
    output logic            sample_valid_o,
    output logic            sample_last_o,
    output logic            busy_o,
    output logic            range_err_o
);

    localparam int AW = CW_W + 5;

    lvl_mode_e       mode_in;
    logic [CW_W-1:0] cw_masked;
    logic            cw_oor;
    logic            mode_ok;

    lvl_mode_e       mode_q;
    logic [CW_W-1:0] val_q;
    logic [SW-1:0]   smp_q;
    logic            vld_q;
    logic            lst_q;
    logic            err_q;

    logic            load;
    logic            busy;
    logic            emit_last;
    logic signed [AW-1:0] q_est;
    logic [AW-1:0]   q_exact;
    logic [AW-1:0]   r_exact;
    logic [SW-1:0]   div_cur;

    // Input qualification: mode legality, width masking, range check
    always_comb begin
        mode_in   = lvl_mode_e'(mode_i);
        mode_ok   = (mode_in != LVL_RSVD);
        cw_masked = codeword_i & CW_W'((32'd1 << lvl_cw_bits(mode_in)) - 32'd1);
        cw_oor    = (32'(cw_masked) >= lvl_cube(mode_in));
        div_cur   = lvl_divisor(mode_q);
    end

    dg_seq #(.NSMP(N_PER_CW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i && mode_ok),
        .load_o  (load),
        .busy_o  (busy),
        .last_o  (emit_last)
    );

    dg_approx #(.W(CW_W), .AW(AW)) u_approx (
        .val_i   (val_q),
        .mode_i  (mode_q),
        .q_est_o (q_est)
    );

    dg_correct #(.W(CW_W), .AW(AW)) u_correct (
        .val_i   (val_q),
        .q_est_i (q_est),
        .mode_i  (mode_q),
        .q_o     (q_exact),
        .r_o     (r_exact)
    );

    // Working value: load a new codeword or recirculate the quotient
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q  <= '0;
            mode_q <= LVL3;
        end else if (load) begin
            val_q  <= cw_masked;
            mode_q <= mode_in;
        end else if (busy) begin
            val_q  <= q_exact[CW_W-1:0];
        end
    end

    // Output sample register with valid and last flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= '0;
            vld_q <= 1'b0;
            lst_q <= 1'b0;
        end else begin
            vld_q <= busy;
            lst_q <= emit_last;
            if (busy) smp_q <= r_exact[SW-1:0];
        end
    end

    // Sticky out-of-range flag
    always_ff @(posedge clk) begin
        if (!rst_n)               err_q <= 1'b0;
        else if (load && cw_oor)  err_q <= 1'b1;
    end

    assign sample_o       = smp_q;
    assign sample_valid_o = vld_q;
    assign sample_last_o  = lst_q;
    assign busy_o         = busy;
    assign range_err_o    = err_q;

    // R2: corrected quotient and remainder reconstruct the working value
    assert_div_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q_exact * AW'(div_cur) + r_exact == AW'(val_q)));

    // R3: the remainder fits the sample port and stays below the divisor
    assert_rem_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_exact[AW-1:SW] == '0 && r_exact[SW-1:0] < div_cur));

    // R2: the recirculated quotient never exceeds the codeword width
    assert_quot_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q_exact[AW-1:CW_W] == '0));

    // R3: each issued sample is below the level count of its codeword
    assert_sample_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (sample_o < $past(div_cur)));

    // R4: last only ever marks a valid sample
    assert_last_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_last_o |-> sample_valid_o);

    // R8: the range flag never clears without reset
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        range_err_o |=> range_err_o);

endmodule

// File: tb/sim_triplet_degrouper.sv
// Directed bench for triplet_degrouper: one task per scenario.
module sim_triplet_degrouper;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [9:0] cw = '0;
    logic [3:0] sample;
    logic       vld, last, busy, err;

    int  n_checks = 0;
    int  n_err    = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    triplet_degrouper u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .mode_i         (mode),
        .codeword_i     (cw),
        .sample_o       (sample),
        .sample_valid_o (vld),
        .sample_last_o  (last),
        .busy_o         (busy),
        .range_err_o    (err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int levels(input int m);
        return (m == 0) ? 3 : (m == 1) ? 5 : 9;
    endfunction

    function automatic int cw_bits(input int m);
        return (m == 0) ? 5 : (m == 1) ? 7 : 10;
    endfunction

    // Present one start for a single edge; returns at the falling edge after it
    task automatic issue(input int m, input int c);
        @(negedge clk);
        start = 1'b1;
        mode  = m[1:0];
        cw    = c[9:0];
        @(negedge clk);
        start = 1'b0;
    endtask

    // Compare the next three samples against bench-computed digits
    task automatic triplet_check(input int m, input int c, input string req);
        int v = c % (1 << cw_bits(m));
        int act = 0;
        int exp = 0;
        bit ok = 1'b1;
        for (int j = 0; j < 3; j++) begin
            int e;
            @(negedge clk);
            e = v % levels(m);
            v = v / levels(m);
            ok &= (vld === 1'b1) && (last === (j == 2)) && (int'(sample) == e);
            act = act * 16 + int'(sample) + (vld ? 0 : 4096);
            exp = exp * 16 + e;
        end
        check(ok, req, $sformatf("mode %0d cw %0d", m, c), act, exp);
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        check(vld == 1'b0 && last == 1'b0, "R9", "valid/last after reset", int'({vld, last}), 0);
        check(busy == 1'b0, "R9", "busy after reset", int'(busy), 0);
        check(err == 1'b0, "R9", "error after reset", int'(err), 0);
    endtask

    task automatic t_all_codes;
        for (int m = 0; m < 3; m++) begin
            for (int c = 0; c < levels(m) ** 3; c++) begin
                issue(m, c);
                triplet_check(m, c, "R1 R2 R3");
            end
        end
        check(err == 1'b0, "R8", "no error for in-range codes", int'(err), 0);
    endtask

    task automatic t_timing;
        issue(2, 500);
        check(busy == 1'b1, "R7", "busy after accept", int'(busy), 1);
        check(vld == 1'b0, "R4", "no valid right after accept", int'(vld), 0);
        triplet_check(2, 500, "R2 R4");
        check(sample < 4'd9, "R3", "sample below 9", int'(sample), 6);
        @(negedge clk);
        check(vld == 1'b0 && last == 1'b0, "R4", "valid drops after third", int'({vld, last}), 0);
        check(busy == 1'b0, "R7", "idle after third sample", int'(busy), 0);
    endtask

    task automatic t_masking;
        issue(0, 10'b11111_00101);      // low 5 bits = 5
        triplet_check(0, 5, "R5");
        issue(1, 10'b111_0000011);      // low 7 bits = 3
        triplet_check(1, 3, "R5");
        check(err == 1'b0, "R5", "masked bits not range-checked", int'(err), 0);
    endtask

    task automatic t_ignore_busy;
        issue(1, 100);                  // digits 0,0,4
        start = 1'b1; mode = 2'd2; cw = 10'd728;
        @(negedge clk);                 // start seen at first-sample edge
        check(vld && sample == 4'd0, "R7", "first sample unaffected", int'(sample), 0);
        @(negedge clk);                 // start seen at second-sample edge
        check(vld && sample == 4'd0, "R7", "second sample unaffected", int'(sample), 0);
        start = 1'b0;
        @(negedge clk);
        check(vld && last && sample == 4'd4, "R7", "third sample unaffected", int'(sample), 4);
        @(negedge clk);
        check(!vld && !busy, "R7", "ignored starts leave no work", int'({vld, busy}), 0);
    endtask

    task automatic t_back_to_back;
        issue(2, 728);                  // digits 8,8,8
        @(negedge clk);
        check(vld && sample == 4'd8, "R6", "first of leading codeword", int'(sample), 8);
        @(negedge clk);
        check(vld && sample == 4'd8, "R6", "second of leading codeword", int'(sample), 8);
        start = 1'b1; mode = 2'd0; cw = 10'd26;
        @(negedge clk);                 // start seen at third-sample edge
        start = 1'b0;
        check(vld && last && sample == 4'd8, "R6", "third of leading codeword", int'(sample), 8);
        check(busy == 1'b1, "R6", "busy held across chain", int'(busy), 1);
        triplet_check(0, 26, "R6");
    endtask

    task automatic t_reserved_mode;
        bit quiet = 1'b1;
        issue(3, 5);
        for (int k = 0; k < 4; k++) begin
            quiet &= !vld && !busy;
            @(negedge clk);
        end
        check(quiet, "R1", "reserved mode ignored", int'(!quiet), 0);
    endtask

    task automatic t_out_of_range;
        issue(2, 1000);
        check(err == 1'b1, "R8", "flag set on 1000 in mode 2", int'(err), 1);
        triplet_check(2, 1000, "R8");
        issue(0, 4);
        triplet_check(0, 4, "R8");
        check(err == 1'b1, "R8", "flag sticky", int'(err), 1);
        issue(0, 31);
        triplet_check(0, 31, "R8");
    endtask

    task automatic t_mid_reset;
        issue(1, 7);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!vld && !last && !busy, "R9", "outputs cleared mid-codeword", int'({vld, last, busy}), 0);
        check(err == 1'b0, "R9", "error cleared", int'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!vld && !busy, "R9", "no resume after reset", int'({vld, busy}), 0);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL R2 watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
            summary();
            $finish;
        end
    end

    // Scenario sequence
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_all_codes();
        t_timing();
        t_masking();
        t_ignore_busy();
        t_back_to_back();
        t_reserved_mode();
        t_out_of_range();
        t_mid_reset();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule